// File: doc/BRIEF.md
# Eight-Bit Stack Machine Core

This block is a small multi-cycle processor. It holds 256 bytes of memory that serve as both program and data space, and eight 8-bit general registers. Register 7 also works as the stack pointer for a stack that lives in memory. Each instruction takes one cycle to read its opcode, one cycle for each operand byte, and one cycle to execute. The top two bits of the opcode give the number of operand bytes, so the core reads only the bytes an instruction uses.

A host loads a program through a byte-wide write port while it holds the core in reset. When reset is released, the core runs from address 0 until it reaches a halt instruction or an opcode it does not recognise. The print instruction places a register value on an output bus together with a one-cycle strobe. The halt and illegal-opcode conditions are each shown on their own flag.

Top module: `stack8_core`

## Requirements
- R1: While reset is low, `prn_valid`, `halted` and `illegal` are 0. After reset is released, execution starts at address 0. Register 7 starts at 0xF4 and registers 0 to 6 start at 0.
- R2: A load write stores `ld_data` at `ld_addr` only while `rst_n` is low. Load writes made while the core runs have no effect.
- R3: Opcode bits [7:6] give the operand count (0, 1 or 2). An instruction occupies 2 + count clock cycles: opcode read, operand reads, execute.
- R4: A register operand names a register by its low three bits. Load-immediate (0x82) writes operand B into register A and advances the PC by 3.
- R5: Print (0x47) drives register A on `prn_data` with `prn_valid` high for exactly one cycle, the cycle after its execute cycle. It advances the PC by 2.
- R6: Add (0xA0) and multiply (0xA2) write A op B into register A, keeping the result modulo 256. Each advances the PC by 3.
- R7: Push (0x45) decrements R7 and then stores register A at memory[R7]. Pop (0x46) loads memory[R7] into register A and then increments R7. Both advance the PC by 2, and values come back in last-in first-out order.
- R8: The stack pointer wraps modulo 256, so a push with R7 = 0x00 leaves R7 at 0xFF.
- R9: Call (0x50) decrements R7, stores PC+2 at memory[R7], and jumps to the address held in register A. Return (0x11) loads the PC from memory[R7] and then increments R7.
- R10: Halt (0x01) sets `halted`. Once `halted` is set it stays set and nothing more is printed until the next reset.
- R11: Any opcode outside the nine listed above sets both `illegal` and `halted` one cycle after the opcode is read, and the core executes nothing further.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; the load port is usable only while it is low |
| ld_we | input | 1 | Load-port write enable |
| ld_addr | input | 8 | Load-port byte address |
| ld_data | input | 8 | Load-port byte value |
| prn_valid | output | 1 | One-cycle strobe marking a print |
| prn_data | output | 8 | Printed register value |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Core stopped on an unrecognised opcode |

## Verification
The properties assume that reset is held low long enough for loading and is released only at a clock boundary. They also assume that the loaded programs keep the stack clear of the program bytes, so that stack writes never overwrite code that is still running. The bench loads every program byte under reset and places the stack traffic at high addresses. Only one test drives the load port after release, and it does so on purpose to show that those writes are ignored. Each program ends in a halt or an illegal byte, so every run reaches the halted state.

// File: rtl/stack8_pkg.sv
package stack8_pkg;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_OPA,
        ST_OPB,
        ST_EXEC,
        ST_HALT
    } fsm_e;

    typedef enum logic [3:0] {
        K_HLT,
        K_LDI,
        K_PRN,
        K_ADD,
        K_MUL,
        K_PUSH,
        K_POP,
        K_CALL,
        K_RET,
        K_BAD
    } kind_e;

    localparam logic [7:0] OPC_HLT  = 8'h01;
    localparam logic [7:0] OPC_RET  = 8'h11;
    localparam logic [7:0] OPC_PUSH = 8'h45;
    localparam logic [7:0] OPC_POP  = 8'h46;
    localparam logic [7:0] OPC_PRN  = 8'h47;
    localparam logic [7:0] OPC_CALL = 8'h50;
    localparam logic [7:0] OPC_LDI  = 8'h82;
    localparam logic [7:0] OPC_ADD  = 8'hA0;
    localparam logic [7:0] OPC_MUL  = 8'hA2;

endpackage

// File: rtl/stack8_mem.sv
module stack8_mem #(
    parameter int W     = 8,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] cells [DEPTH];

    // Cells have no reset so that loaded contents survive the core's reset.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/stack8_decode.sv
module stack8_decode
    import stack8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] opc,
    output kind_e        kind,
    output logic [1:0]   nops
);

    // Operand count lives in the two top bits of every opcode.
    assign nops = opc[W-1:W-2];

    always_comb begin
        case (opc)
            W'(OPC_HLT):  kind = K_HLT;
            W'(OPC_LDI):  kind = K_LDI;
            W'(OPC_PRN):  kind = K_PRN;
            W'(OPC_ADD):  kind = K_ADD;
            W'(OPC_MUL):  kind = K_MUL;
            W'(OPC_PUSH): kind = K_PUSH;
            W'(OPC_POP):  kind = K_POP;
            W'(OPC_CALL): kind = K_CALL;
            W'(OPC_RET):  kind = K_RET;
            default:      kind = K_BAD;
        endcase
    end

endmodule

// File: rtl/stack8_alu.sv
module stack8_alu #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         mul,
    output logic [W-1:0] y
);

    logic [W-1:0] sum;
    logic [W-1:0] prod;

    // Both results are truncated to the word width.
    assign sum  = a + b;
    assign prod = a * b;
    assign y    = mul ? prod : sum;

endmodule

// File: rtl/stack8_core.sv
module stack8_core
    import stack8_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int NREGS   = 8,
    parameter int SP_IDX  = 7,
    parameter int SP_INIT = 'hF4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_we,
    input  logic [DATA_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    output logic              prn_valid,
    output logic [DATA_W-1:0] prn_data,
    output logic              halted,
    output logic              illegal
);

    localparam int MEM_DEPTH = 1 << DATA_W;
    localparam int RIDX_W    = $clog2(NREGS);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
    localparam logic [DATA_W-1:0] TWO = DATA_W'(2);
    localparam logic [DATA_W-1:0] THREE = DATA_W'(3);

    typedef struct packed {
        fsm_e                          fsm;
        logic [DATA_W-1:0]             pc;
        logic [DATA_W-1:0]             opc;
        logic [RIDX_W-1:0]             opa;
        logic [DATA_W-1:0]             opb;
        logic [NREGS-1:0][DATA_W-1:0]  regs;
        logic                          prn_v;
        logic [DATA_W-1:0]             prn_d;
        logic                          bad;
    } core_s;

    core_s q, d;

    logic [DATA_W-1:0] mem_raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic              exec_we;
    logic [DATA_W-1:0] exec_waddr;
    logic [DATA_W-1:0] exec_wdata;
    logic              mem_we;
    logic [DATA_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;

    logic [DATA_W-1:0] dec_in;
    kind_e             kind;
    logic [1:0]        nops;

    logic [DATA_W-1:0] reg_a;
    logic [DATA_W-1:0] reg_b;
    logic [DATA_W-1:0] alu_y;
    logic [DATA_W-1:0] sp_q;
    logic [DATA_W-1:0] sp_dec;

    // Load port owns the write side only while reset is held.
    assign mem_we    = rst_n ? exec_we    : ld_we;
    assign mem_waddr = rst_n ? exec_waddr : ld_addr;
    assign mem_wdata = rst_n ? exec_wdata : ld_data;

    stack8_mem #(
        .W     (DATA_W),
        .DEPTH (MEM_DEPTH)
    ) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    // Opcode is decoded straight from memory in the fetch cycle, latched after.
    assign dec_in = (q.fsm == ST_FETCH) ? mem_rdata : q.opc;

    stack8_decode #(
        .W (DATA_W)
    ) u_dec (
        .opc  (dec_in),
        .kind (kind),
        .nops (nops)
    );

    assign reg_a  = q.regs[q.opa];
    assign reg_b  = q.regs[q.opb[RIDX_W-1:0]];
    assign sp_q   = q.regs[SP_IDX];
    assign sp_dec = sp_q - ONE;

    stack8_alu #(
        .W (DATA_W)
    ) u_alu (
        .a   (reg_a),
        .b   (reg_b),
        .mul (kind == K_MUL),
        .y   (alu_y)
    );

    always_comb begin
        d          = q;
        d.prn_v    = 1'b0;
        mem_raddr  = q.pc;
        exec_we    = 1'b0;
        exec_waddr = sp_dec;
        exec_wdata = reg_a;

        case (q.fsm)
            ST_FETCH: begin
                mem_raddr = q.pc;
                d.opc     = mem_rdata;
                if (kind == K_BAD) begin
                    d.bad = 1'b1;
                    d.fsm = ST_HALT;
                end else if (nops == 2'd0) begin
                    d.fsm = ST_EXEC;
                end else begin
                    d.fsm = ST_OPA;
                end
            end

            ST_OPA: begin
                mem_raddr = q.pc + ONE;
                d.opa     = mem_rdata[RIDX_W-1:0];
                d.fsm     = (nops == 2'd2) ? ST_OPB : ST_EXEC;
            end

            ST_OPB: begin
                mem_raddr = q.pc + TWO;
                d.opb     = mem_rdata;
                d.fsm     = ST_EXEC;
            end

            ST_EXEC: begin
                mem_raddr = sp_q;
                d.fsm     = ST_FETCH;
                case (kind)
                    K_HLT: begin
                        d.pc  = q.pc + ONE;
                        d.fsm = ST_HALT;
                    end
                    K_LDI: begin
                        d.regs[q.opa] = q.opb;
                        d.pc          = q.pc + THREE;
                    end
                    K_PRN: begin
                        d.prn_v = 1'b1;
                        d.prn_d = reg_a;
                        d.pc    = q.pc + TWO;
                    end
                    K_ADD, K_MUL: begin
                        d.regs[q.opa] = alu_y;
                        d.pc          = q.pc + THREE;
                    end
                    K_PUSH: begin
                        d.regs[SP_IDX] = sp_dec;
                        exec_we        = 1'b1;
                        exec_wdata     = d.regs[q.opa];
                        d.pc           = q.pc + TWO;
                    end
                    K_POP: begin
                        d.regs[q.opa]  = mem_rdata;
                        d.regs[SP_IDX] = d.regs[SP_IDX] + ONE;
                        d.pc           = q.pc + TWO;
                    end
                    K_CALL: begin
                        d.regs[SP_IDX] = sp_dec;
                        exec_we        = 1'b1;
                        exec_wdata     = q.pc + TWO;
                        d.pc           = d.regs[q.opa];
                    end
                    K_RET: begin
                        d.pc           = mem_rdata;
                        d.regs[SP_IDX] = sp_q + ONE;
                    end
                    default: begin
                        d.bad = 1'b1;
                        d.fsm = ST_HALT;
                    end
                endcase
            end

            default: begin
                d.fsm = ST_HALT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q              <= '0;
            q.fsm          <= ST_FETCH;
            q.regs[SP_IDX] <= DATA_W'(SP_INIT);
        end else begin
            q <= d;
        end
    end

    assign prn_valid = q.prn_v;
    assign prn_data  = q.prn_d;
    assign halted    = (q.fsm == ST_HALT);
    assign illegal   = q.bad;

endmodule

// File: rtl/stack8_core_chk.sv
module stack8_core_chk (
    input logic clk,
    input logic rst_n,
    input logic prn_valid,
    input logic halted,
    input logic illegal
);

    // R5
    prn_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prn_valid |=> !prn_valid);

    // R10
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R10
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !prn_valid);

    // R11
    bad_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> halted);

    // R11
    bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> illegal);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!rst_n) |-> (!halted && !illegal && !prn_valid));

endmodule

bind stack8_core stack8_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prn_valid (prn_valid),
    .halted    (halted),
    .illegal   (illegal)
);

// File: tb/stack8_core_test.sv
module stack8_core_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_we = 1'b0;
    logic [7:0] ld_addr = 8'h00;
    logic [7:0] ld_data = 8'h00;
    logic       prn_valid;
    logic [7:0] prn_data;
    logic       halted;
    logic       illegal;

    int nchk = 0;
    int nfail = 0;

    logic [7:0] img [256];
    int         wp;
    logic [7:0] plog [16];
    int         pcyc [16];
    int         pcount = 0;
    int         cyc = 0;
    int         hcyc = -1;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    stack8_core uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_we     (ld_we),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .prn_valid (prn_valid),
        .prn_data  (prn_data),
        .halted    (halted),
        .illegal   (illegal)
    );

    // Observer: counts cycles since release and records print strobes.
    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0;
        end else begin
            cyc++;
            if (prn_valid) begin
                if (pcount < 16) begin
                    plog[pcount] = prn_data;
                    pcyc[pcount] = cyc;
                end
                pcount++;
            end
            if (halted && hcyc < 0) hcyc = cyc;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic clear_img();
        for (int i = 0; i < 256; i++) img[i] = 8'h00;
        wp = 0;
    endtask

    task automatic emit(input logic [7:0] b);
        img[wp[7:0]] = b;
        wp++;
    endtask

    task automatic i_ldi(input logic [7:0] r, input logic [7:0] v);
        emit(8'h82); emit(r); emit(v);
    endtask
    task automatic i_prn(input logic [7:0] r);  emit(8'h47); emit(r); endtask
    task automatic i_push(input logic [7:0] r); emit(8'h45); emit(r); endtask
    task automatic i_pop(input logic [7:0] r);  emit(8'h46); emit(r); endtask
    task automatic i_call(input logic [7:0] r); emit(8'h50); emit(r); endtask
    task automatic i_ret();  emit(8'h11); endtask
    task automatic i_hlt();  emit(8'h01); endtask
    task automatic i_add(input logic [7:0] a, input logic [7:0] b);
        emit(8'hA0); emit(a); emit(b);
    endtask
    task automatic i_mul(input logic [7:0] a, input logic [7:0] b);
        emit(8'hA2); emit(a); emit(b);
    endtask

    task automatic boot();
        @(negedge clk); #5;
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk); #5;
            ld_we   = 1'b1;
            ld_addr = 8'(i);
            ld_data = img[i];
        end
        @(negedge clk); #5;
        ld_we  = 1'b0;
        pcount = 0;
        hcyc   = -1;
    endtask

    task automatic go();
        int guard;
        @(negedge clk); #5;
        rst_n = 1'b1;
        guard = 0;
        while (!halted && guard < 600) begin
            @(negedge clk); #1;
            guard++;
        end
        repeat (4) @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        clear_img();
        i_prn(8'd7); i_prn(8'd3); i_hlt();
        boot();
        repeat (2) @(negedge clk);
        #1;
        check("R1 halted in reset", int'(halted), 0);
        check("R1 illegal in reset", int'(illegal), 0);
        check("R1 prn_valid in reset", int'(prn_valid), 0);
        go();
        check("R1 print count", pcount, 2);
        check("R1 R7 reset value", int'(plog[0]), 'hF4);
        check("R1 R3 reset value", int'(plog[1]), 0);
    endtask

    task automatic t_timing();
        clear_img();
        i_ldi(8'd0, 8'd7); i_prn(8'd0); i_hlt();
        boot(); go();
        check("R4 ldi value printed", int'(plog[0]), 7);
        check("R5 print cycle", pcyc[0], 7);
        check("R3 cycles to halt", hcyc, 9);
        check("R5 single pulse", pcount, 1);
    endtask

    task automatic t_arith();
        clear_img();
        i_ldi(8'd0, 8'd8); i_ldi(8'd1, 8'd9); i_mul(8'd0, 8'd1); i_prn(8'd0);
        i_ldi(8'd2, 8'd20); i_mul(8'd2, 8'd2); i_prn(8'd2);
        i_ldi(8'd3, 8'd200); i_ldi(8'd4, 8'd100); i_add(8'd3, 8'd4);
        i_prn(8'h0B); i_hlt();
        boot(); go();
        check("R6 print count", pcount, 3);
        check("R6 mul", int'(plog[0]), 72);
        check("R6 mul wraps", int'(plog[1]), 144);
        check("R6 add wraps / R4 low index bits", int'(plog[2]), 44);
    endtask

    task automatic t_stack();
        clear_img();
        i_ldi(8'd0, 8'd5); i_ldi(8'd1, 8'd6); i_push(8'd0); i_push(8'd1);
        i_prn(8'd7); i_pop(8'd2); i_pop(8'd3);
        i_prn(8'd2); i_prn(8'd3); i_prn(8'd7); i_hlt();
        boot(); go();
        check("R7 print count", pcount, 4);
        check("R7 sp after two pushes", int'(plog[0]), 'hF2);
        check("R7 first pop", int'(plog[1]), 6);
        check("R7 second pop", int'(plog[2]), 5);
        check("R7 sp restored", int'(plog[3]), 'hF4);
    endtask

    task automatic t_wrap();
        clear_img();
        i_ldi(8'd7, 8'd0); i_ldi(8'd0, 8'h5A); i_push(8'd0); i_prn(8'd7);
        i_pop(8'd1); i_prn(8'd1); i_prn(8'd7); i_hlt();
        boot(); go();
        check("R8 sp wraps down", int'(plog[0]), 'hFF);
        check("R8 pop at 0xFF", int'(plog[1]), 'h5A);
        check("R8 sp wraps up", int'(plog[2]), 0);
    endtask

    task automatic t_call();
        clear_img();
        i_ldi(8'd1, 8'h20); i_call(8'd1); i_prn(8'd0); i_prn(8'd7); i_hlt();
        wp = 'h20;
        i_ldi(8'd0, 8'h33); i_prn(8'd7); i_ret();
        boot(); go();
        check("R9 print count", pcount, 3);
        check("R9 sp inside call", int'(plog[0]), 'hF3);
        check("R9 returned after call", int'(plog[1]), 'h33);
        check("R9 sp after return", int'(plog[2]), 'hF4);
        check("R9 not illegal", int'(illegal), 0);
    endtask

    task automatic t_halt();
        clear_img();
        i_hlt(); i_prn(8'd7);
        boot(); go();
        check("R10 cycles to halt", hcyc, 2);
        repeat (10) @(negedge clk);
        #1;
        check("R10 stays halted", int'(halted), 1);
        check("R10 no print after halt", pcount, 0);
        check("R10 not illegal", int'(illegal), 0);
    endtask

    task automatic t_illegal();
        clear_img();
        i_ldi(8'd0, 8'd1); emit(8'hA1); i_prn(8'd0); i_hlt();
        boot(); go();
        check("R11 illegal flag", int'(illegal), 1);
        check("R11 halted", int'(halted), 1);
        check("R11 halt cycle", hcyc, 5);
        check("R11 nothing printed", pcount, 0);
    endtask

    task automatic t_load_ignored();
        clear_img();
        i_ldi(8'd0, 8'h11); i_ldi(8'd0, 8'h22); i_prn(8'd0); i_hlt();
        boot();
        @(negedge clk); #5;
        rst_n = 1'b1;
        @(negedge clk); #5;
        ld_we   = 1'b1;
        ld_addr = 8'd6;
        ld_data = 8'h01;
        repeat (3) @(negedge clk);
        #5;
        ld_we = 1'b0;
        for (int g = 0; g < 100 && !halted; g++) @(negedge clk);
        repeat (3) @(negedge clk);
        #1;
        check("R2 run-time load ignored", pcount, 1);
        check("R2 original code ran", int'(plog[0]), 'h22);
    endtask

    initial begin
        t_reset();
        t_timing();
        t_arith();
        t_stack();
        t_wrap();
        t_call();
        t_halt();
        t_illegal();
        t_load_ignored();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

endmodule